// File: doc/BRIEF.md
# DSP Paged Memory Address Decoder

This block sits between a digital signal processor with a 16-bit address bus and its memories: a large byte-wide ROM and two RAM banks. On every bus cycle it looks at the address, the read and write strobes and three memory-space selects: boot, data and program. From these it picks a single target. That target can be the ROM, the data-side RAM bank, the program-side RAM bank or the host command port. The block can also pick nothing. Every target enable is registered, so it appears one clock after the bus inputs are sampled.

The ROM spans 16 MB. Only ten of its address bits come straight from the processor. The upper fourteen come from an internal page register. The processor sees just eight data bits, so it loads the page in two byte-wide register writes. A third register write drives a status LED, which the firmware toggles to show that it is alive. Register writes take effect once per write strobe, on its rising edge, so a long write cycle cannot load a register twice.

Top module: `dsp_page_decoder`

## Requirements
- R1: After reset every enable output, `cmd_rd` and `led` are 0 and the page register is 0, so the first boot read drives `rom_addr` = {14'h0, addr[9:0]}.
- R2: A read with `sel_boot` high asserts `rom_en` one clock later, with `rom_addr` = {page, addr[9:0]}.
- R3: A data-space read with addr[15:10] = 0 asserts `rom_en` one clock later, with `rom_addr` = {page, addr[9:0]}.
- R4: A data-space read or write with addr[15] = 1 asserts `ram_en_d`. Any program-space read or write asserts `ram_en_p`. Both appear one clock later.
- R5: A data-space read of address 0x4000 asserts `cmd_rd` one clock later.
- R6: A data-space write to 0x4001 loads page bits 7:0 from the data bus. A write to 0x4002 loads page bits 13:8 from data bits 5:0 and ignores data bits 7:6.
- R7: The page register changes only on the rising edge of `bus_wr`. If the data changes while the strobe is held high, the page keeps the value from the first cycle.
- R8: A data-space write to 0x4003 loads data bit 0 into `led`, which is visible one clock later.
- R9: At most one of `rom_en`, `ram_en_d`, `ram_en_p`, `cmd_rd` is high in any cycle. When several selects are high, boot wins over program, and program wins over data.
- R10: Writes in boot space or in the data-space ROM window, reads of registers 0x4001 to 0x4003, and data-space accesses to addresses that map to nothing assert no enable and leave the page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Processor address bus |
| bus_data | input | 8 | Low byte of the processor data bus |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| sel_boot | input | 1 | Boot memory space select |
| sel_data | input | 1 | Data memory space select |
| sel_prog | input | 1 | Program memory space select |
| rom_addr | output | 24 | ROM byte address: page and low address bits |
| rom_en | output | 1 | ROM read enable |
| ram_en_d | output | 1 | Data-side RAM bank enable |
| ram_en_p | output | 1 | Program-side RAM bank enable |
| cmd_rd | output | 1 | Host command port read strobe |
| led | output | 1 | Status LED register |

## Verification
Two targets can claim the same cycle when the processor raises more than one space select. For example, a boot read aimed at a RAM address with the data select also high could enable both the ROM and a RAM bank. The bench provokes this by driving every pairing of selects, and the full triple, against ROM-window, RAM and command addresses. It judges the result by checking that exactly the target chosen by the boot, program, data priority is enabled and that no other enable is high. A second collision, a register load arriving while earlier data is still on the bus, is provoked by holding the write strobe while the data changes, and is judged by reading the page back through a following boot read.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

  // Decoded destination of one bus cycle.
  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_ROM   = 3'd1,
    TGT_RAM_D = 3'd2,
    TGT_RAM_P = 3'd3,
    TGT_CMD   = 3'd4
  } dpd_tgt_e;

  // Register offsets inside the register block.
  localparam logic [1:0] OFF_CMD  = 2'd0;
  localparam logic [1:0] OFF_PG0  = 2'd1;
  localparam logic [1:0] OFF_LED  = 2'd3;

endpackage

// File: rtl/dpd_space_decode.sv
module dpd_space_decode
  import dpd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LOW_W    = 10,
  parameter logic [15:0] REG_BASE = 16'h4000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              sel_boot,
  input  logic              sel_data,
  input  logic              sel_prog,
  output dpd_tgt_e          tgt,
  output logic              reg_hit,
  output logic [1:0]        reg_off
);

  localparam int HI_W = ADDR_W - LOW_W;

  logic in_window;
  logic in_ram;

  always_comb begin
    in_window = (addr[ADDR_W-1:LOW_W] == {HI_W{1'b0}});
    in_ram    = addr[ADDR_W-1];
    reg_off   = addr[1:0];
    reg_hit   = sel_data && !sel_boot && !sel_prog &&
                (addr[ADDR_W-1:2] == REG_BASE[ADDR_W-1:2]);
  end

  // Priority: boot space, then program space, then data space.
  always_comb begin
    tgt = TGT_NONE;
    if (sel_boot) begin
      if (rd) tgt = TGT_ROM;
    end else if (sel_prog) begin
      if (rd || wr) tgt = TGT_RAM_P;
    end else if (sel_data) begin
      if (in_ram) begin
        if (rd || wr) tgt = TGT_RAM_D;
      end else if (in_window) begin
        if (rd) tgt = TGT_ROM;
      end else if (reg_hit && reg_off == OFF_CMD && rd) begin
        tgt = TGT_CMD;
      end
    end
  end

endmodule

// File: rtl/dpd_page_reg.sv
module dpd_page_reg #(
  parameter int PAGE_W = 14,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [((PAGE_W+DATA_W-1)/DATA_W)-1:0] ld,
  input  logic [DATA_W-1:0]   din,
  output logic [PAGE_W-1:0]   page
);

  localparam int NSLICE = (PAGE_W + DATA_W - 1) / DATA_W;

  // Each slice takes one byte write; the top slice keeps only its low bits.
  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    localparam int SW = (g == NSLICE-1) ? (PAGE_W - g*DATA_W) : DATA_W;
    always_ff @(posedge clk) begin
      if (rst) page[g*DATA_W +: SW] <= '0;
      else if (ld[g]) page[g*DATA_W +: SW] <= din[SW-1:0];
    end
  end

  // R7: without a load pulse the page holds.
  p_page_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ld == '0) |=> $stable(page));

endmodule

// File: rtl/dsp_page_decoder.sv
module dsp_page_decoder
  import dpd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LOW_W  = 10,
  parameter int PAGE_W = 14,
  parameter logic [15:0] REG_BASE = 16'h4000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_data,
  input  logic                      bus_rd,
  input  logic                      bus_wr,
  input  logic                      sel_boot,
  input  logic                      sel_data,
  input  logic                      sel_prog,
  output logic [PAGE_W+LOW_W-1:0]   rom_addr,
  output logic                      rom_en,
  output logic                      ram_en_d,
  output logic                      ram_en_p,
  output logic                      cmd_rd,
  output logic                      led
);

  localparam int ROM_AW = PAGE_W + LOW_W;
  localparam int NSLICE = (PAGE_W + DATA_W - 1) / DATA_W;

  dpd_tgt_e           tgt;
  logic               reg_hit;
  logic [1:0]         reg_off;
  logic               wr_q;
  logic               wr_rise;
  logic [NSLICE-1:0]  pg_ld;
  logic [PAGE_W-1:0]  page;

  dpd_space_decode #(
    .ADDR_W   (ADDR_W),
    .LOW_W    (LOW_W),
    .REG_BASE (REG_BASE)
  ) u_dec (
    .addr     (bus_addr),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .sel_boot (sel_boot),
    .sel_data (sel_data),
    .sel_prog (sel_prog),
    .tgt      (tgt),
    .reg_hit  (reg_hit),
    .reg_off  (reg_off)
  );

  assign wr_rise = bus_wr && !wr_q;

  always_comb begin
    for (int i = 0; i < NSLICE; i++)
      pg_ld[i] = wr_rise && reg_hit && (reg_off == OFF_PG0 + 2'(i));
  end

  dpd_page_reg #(
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_page (
    .clk  (clk),
    .rst  (rst),
    .ld   (pg_ld),
    .din  (bus_data),
    .page (page)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= 1'b0;
      rom_en   <= 1'b0;
      ram_en_d <= 1'b0;
      ram_en_p <= 1'b0;
      cmd_rd   <= 1'b0;
      led      <= 1'b0;
      rom_addr <= '0;
    end else begin
      wr_q     <= bus_wr;
      rom_en   <= (tgt == TGT_ROM);
      ram_en_d <= (tgt == TGT_RAM_D);
      ram_en_p <= (tgt == TGT_RAM_P);
      cmd_rd   <= (tgt == TGT_CMD);
      rom_addr <= ROM_AW'({page, bus_addr[LOW_W-1:0]});
      if (wr_rise && reg_hit && reg_off == OFF_LED) led <= bus_data[0];
    end
  end

  // R9: a single target per cycle.
  p_one_target_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_en, ram_en_d, ram_en_p, cmd_rd}));

  // R2: the ROM is only ever read.
  p_rom_on_read_r2: assert property (@(posedge clk) disable iff (rst)
    rom_en |-> $past(bus_rd));

  // R4: program bank follows the program select.
  p_ram_p_sel_r4: assert property (@(posedge clk) disable iff (rst)
    ram_en_p |-> $past(sel_prog));

  // R5: command strobe only on a data-space read.
  p_cmd_read_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_rd |-> $past(bus_rd && sel_data));

  // R8: LED moves only after a write.
  p_led_on_write_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(led) |-> $past(bus_wr));

endmodule

// File: tb/dsp_page_decoder_tb.sv
module dsp_page_decoder_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic [7:0]  bus_data;
  logic        bus_rd, bus_wr, sel_boot, sel_data, sel_prog;
  logic [23:0] rom_addr;
  logic        rom_en, ram_en_d, ram_en_p, cmd_rd, led;

  int checks = 0;
  int errors = 0;

  logic [13:0] m_page = '0;
  logic        m_led  = 1'b0;

  always #5 clk = ~clk;

  dsp_page_decoder u_dut (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_data (bus_data),
    .bus_rd (bus_rd), .bus_wr (bus_wr), .sel_boot (sel_boot),
    .sel_data (sel_data), .sel_prog (sel_prog), .rom_addr (rom_addr),
    .rom_en (rom_en), .ram_en_d (ram_en_d), .ram_en_p (ram_en_p),
    .cmd_rd (cmd_rd), .led (led)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_rd = 0; bus_wr = 0; sel_boot = 0; sel_data = 0; sel_prog = 0;
  endtask

  // Expected {cmd_rd, ram_en_p, ram_en_d, rom_en} from the requirements.
  function automatic logic [3:0] exp_tgt(input logic b, input logic d, input logic p,
                                        input logic r, input logic w, input logic [15:0] a);
    if (b) return {3'b000, r};
    if (p) return {1'b0, r | w, 2'b00};
    if (d) begin
      if (a[15]) return {2'b00, r | w, 1'b0};
      if (a[15:10] == 6'd0) return {3'b000, r};
      if (a == 16'h4000) return {r, 3'b000};
    end
    return 4'b0000;
  endfunction

  // One bus cycle, checked one clock later, followed by an idle clock.
  task automatic access(input logic b, input logic d, input logic p, input logic r,
                        input logic w, input logic [15:0] a, input logic [7:0] dat,
                        input string req);
    logic [3:0] e;
    e = exp_tgt(b, d, p, r, w, a);
    sel_boot = b; sel_data = d; sel_prog = p; bus_rd = r; bus_wr = w;
    bus_addr = a; bus_data = dat;
    if (d && !b && !p && w && a[15:2] == 14'h1000) begin
      if (a[1:0] == 2'd1) m_page[7:0]  = dat;
      if (a[1:0] == 2'd2) m_page[13:8] = dat[5:0];
      if (a[1:0] == 2'd3) m_led        = dat[0];
    end
    @(negedge clk);
    check({req, " enables"}, {28'd0, cmd_rd, ram_en_p, ram_en_d, rom_en}, {28'd0, e});
    if (e[0]) check({req, " rom_addr"}, {8'd0, rom_addr}, {8'd0, m_page, a[9:0]});
    check("R8 led", {31'd0, led}, {31'd0, m_led});
    idle();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; idle(); bus_addr = 0; bus_data = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1 rom_en", {31'd0, rom_en}, 0);
    check("R1 ram enables", {30'd0, ram_en_d, ram_en_p}, 0);
    check("R1 cmd_rd", {31'd0, cmd_rd}, 0);
    check("R1 led", {31'd0, led}, 0);
    access(1, 0, 0, 1, 0, 16'h0155, 8'h00, "R1 first boot read page 0");

    // R6: both page halves, high byte ignoring data bits 7:6
    access(0, 1, 0, 0, 1, 16'h4001, 8'hA5, "R6 page low");
    access(0, 1, 0, 0, 1, 16'h4002, 8'hFF, "R6 page high");
    access(1, 0, 0, 1, 0, 16'h03FF, 8'h00, "R6 R2 boot read after load");
    check("R6 page value", {8'd0, rom_addr}, {8'd0, 14'h3FA5, 10'h3FF});
    access(0, 1, 0, 0, 1, 16'h4002, 8'hC2, "R6 page high masked");
    access(0, 1, 0, 1, 0, 16'h0200, 8'h00, "R3 R6 window read");

    // R7: held write strobe loads once
    sel_data = 1; bus_wr = 1; bus_addr = 16'h4001; bus_data = 8'h12;
    @(negedge clk);
    bus_data = 8'h34;
    @(negedge clk);
    bus_data = 8'h56;
    @(negedge clk);
    idle();
    @(negedge clk);
    m_page[7:0] = 8'h12;
    access(1, 0, 0, 1, 0, 16'h0001, 8'h00, "R7 held write loads once");

    // R10: register reads and ignored writes leave the page alone
    access(0, 1, 0, 1, 0, 16'h4001, 8'h00, "R10 register read");
    access(0, 1, 0, 1, 0, 16'h4002, 8'h00, "R10 register read");
    access(1, 0, 0, 0, 1, 16'h4001, 8'h77, "R10 boot write");
    access(0, 1, 0, 0, 1, 16'h0010, 8'h77, "R10 window write");
    access(0, 1, 0, 1, 0, 16'h5000, 8'h00, "R10 unmapped read");
    access(1, 0, 0, 1, 0, 16'h0002, 8'h00, "R10 page unchanged");

    // R5, R8
    access(0, 1, 0, 1, 0, 16'h4000, 8'h00, "R5 command read");
    access(0, 1, 0, 0, 1, 16'h4000, 8'h00, "R5 command write ignored");
    access(0, 1, 0, 0, 1, 16'h4003, 8'h01, "R8 led on");
    access(0, 1, 0, 0, 1, 16'h4003, 8'hFE, "R8 led off");
    access(0, 1, 0, 0, 1, 16'h4003, 8'h03, "R8 led on again");

    // R9: overlapping selects resolved by priority
    for (int s = 3; s < 8; s++) begin
      if (s == 4) continue;
      access(s[2], s[0], s[1], 1, 0, 16'h8123, 8'h00, "R9 select overlap RAM addr");
      access(s[2], s[0], s[1], 1, 0, 16'h0123, 8'h00, "R9 select overlap window");
      access(s[2], s[0], s[1], 1, 0, 16'h4000, 8'h00, "R9 select overlap command");
      access(s[2], s[0], s[1], 0, 1, 16'h4001, 8'h3C, "R9 R10 overlap write");
    end

    // R2 R3 R4: sweep of addresses, selects and strobes with page changes
    for (int i = 0; i < 256; i++) begin
      logic [15:0] a;
      a = 16'(i * 16'h0101 + 16'h0013);
      if (i % 32 == 0) begin
        access(0, 1, 0, 0, 1, 16'h4001, 8'(i * 7 + 3), "R6 sweep page low");
        access(0, 1, 0, 0, 1, 16'h4002, 8'(i * 5 + 8'hC1), "R6 sweep page high");
      end
      access(1, 0, 0, 1, 0, a, 8'h00, "R2 sweep boot read");
      access(0, 1, 0, 1, 0, a, 8'h00, "R3 R4 sweep data read");
      access(0, 1, 0, 0, 1, a, 8'h00, "R4 sweep data write");
      access(0, 0, 1, 1, 0, a, 8'h00, "R4 sweep program read");
      access(0, 0, 1, 0, 1, a, 8'h00, "R4 sweep program write");
      access(0, 0, 0, 1, 0, a, 8'h00, "R10 sweep no select");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule